// File: doc/BRIEF.md
# Multi-entry BCD count chain

This block is an eight-digit decimal counter built as a chain of 4-bit BCD digits. It is meant to sit in a frequency meter. A single-cycle count pulse can be fed in at one of four digit positions. This lets the same chain show a kHz or a Hz reading for a long or short gate without a separate prescaler. In counter and timer use, a mode input forces the pulses into the lowest displayed digit.

All digits share one clock and advance through per-digit enables. A carry ripples through the whole chain within the cycle of the pulse that causes it. Only the five upper digits are brought out, and they go through display registers. Those registers follow the chain while the latch enable is high and hold while it is low, so the reading stays steady between gates.

A carry out of the top digit sets a sticky overflow flop. That overflow reaches the output only when the display is latched. A synchronous clear restarts the count for the next gate period and leaves the displayed reading alone.

Top module: `bcd_count_chain`

## Requirements
- R1: Each digit holds a value from 0 to 9. An advancing digit at 9 becomes 0 and advances the next digit up at the same clock edge, so a long carry settles in one cycle.
- R2: With cnt_mode low, tap_sel selects where pulses enter: 0 gives digit 0, 1 gives digit 1, 2 gives digit 3 and 3 gives digit 4. A pulse adds one to that digit.
- R3: With cnt_mode high, every pulse enters at digit 3 whatever tap_sel holds.
- R4: Digits below the active entry digit are cleared at every edge and stay zero. A remainder left by an earlier, lower entry point is therefore dropped when a higher one is selected.
- R5: A carry out of digit 7 sets a sticky overflow flag, and the digits wrap to zero. Further counting does not clear the flag.
- R6: disp_digits holds digits 3 to 7, with digit 3+i in bits [4i+3:4i]. It takes the chain value from before an edge at which disp_le is high, and it holds at every edge where disp_le is low.
- R7: disp_ovf takes the sticky overflow flag at each edge where disp_le is high and holds otherwise.
- R8: ctr_clr high at an edge clears all digits and the sticky flag, and it wins over a pulse at that edge. disp_digits and disp_ovf are not changed by it.
- R9: rst_n low at an edge clears all digits, the sticky flag, disp_digits and disp_ovf.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cnt_pulse | input | 1 | Single-cycle count event |
| tap_sel | input | 2 | Entry digit select in frequency mode |
| cnt_mode | input | 1 | 1 = counter/timer use, entry fixed at digit 3 |
| ctr_clr | input | 1 | Synchronous clear of chain and sticky overflow |
| disp_le | input | 1 | Display latch enable |
| disp_digits | output | 20 | Displayed digits 3..7, four bits each |
| disp_ovf | output | 1 | Displayed overflow flag |

## Verification
A pulse or a clear changes the chain at the edge where it is sampled. That chain value reaches disp_digits and disp_ovf at the next edge with disp_le high. The result is therefore readable half a cycle after that latch edge.

The driver raises disp_le for one cycle and queues the reading the requirements predict for the count at that moment. The monitor pops the queued reading at the falling edge after the latch edge and compares it with the outputs. Hold and ignore cases (no latch, a clear, an overflow not yet latched) are compared directly at a falling edge, against the last reading that was latched.

// File: rtl/bcd_chain_pkg.sv
// Package for the BCD count chain: the entry-point select encoding and its
// mapping to a digit position. Assumes digit positions fit in an int.
package bcd_chain_pkg;

    localparam int BCD_W       = 4;
    localparam int CNT_TAP_POS = 3;

    typedef enum logic [1:0] {
        TAP_U0 = 2'd0,
        TAP_U1 = 2'd1,
        TAP_U3 = 2'd2,
        TAP_U4 = 2'd3
    } tap_e;

    // Map a tap code to the digit index that receives the pulse.
    function automatic int tap_position(input tap_e t);
        case (t)
            TAP_U0:  return 0;
            TAP_U1:  return 1;
            TAP_U3:  return 3;
            default: return 4;
        endcase
    endfunction

endpackage

// File: rtl/bcd_entry_sel.sv
// Entry-point decoder: turns the pulse, tap select and mode into a per-digit
// injection vector and a mask of digits that lie below the entry point.
// Assumes NUM_DIGITS > 4 so every tap position exists.
module bcd_entry_sel
    import bcd_chain_pkg::*;
#(
    parameter int NUM_DIGITS = 8
) (
    input  logic                  pulse,
    input  logic [1:0]            tap_sel,
    input  logic                  cnt_mode,
    output logic [NUM_DIGITS-1:0] inject,
    output logic [NUM_DIGITS-1:0] below
);

    int tap_pos;

    // Pick the entry digit and build the inject and below-entry vectors.
    always_comb begin
        tap_pos = cnt_mode ? CNT_TAP_POS : tap_position(tap_e'(tap_sel));
        for (int i = 0; i < NUM_DIGITS; i++) begin
            inject[i] = pulse && (tap_pos == i);
            below[i]  = (i < tap_pos);
        end
    end

endmodule

// File: rtl/bcd_digit_cell.sv
// One BCD digit of the chain. It advances on step unless cleared or held at
// zero, and raises a combinational carry when it wraps from 9 to 0.
// Assumes a single clock; clear and hold take priority over step.
module bcd_digit_cell
    import bcd_chain_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             hold_zero,
    input  logic             step,
    output logic [BCD_W-1:0] val,
    output logic             carry
);

    logic advance;

    // Qualify the step and form the wrap carry.
    always_comb begin
        advance = step && !clr && !hold_zero;
        carry   = advance && (val == 4'd9);
    end

    // Digit register with clear, hold and decimal wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || hold_zero) begin
            val <= '0;
        end else if (advance) begin
            val <= (val == 4'd9) ? '0 : val + 4'd1;
        end
    end

    // R1
    digit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        val <= 4'd9);

    // R1
    digit_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clr && !hold_zero && val == 4'd9) |=> (val == 4'd0));

    // R1
    digit_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clr && !hold_zero && val < 4'd9) |=> (val == $past(val) + 4'd1));

endmodule

// File: rtl/bcd_disp_hold.sv
// Display hold registers: copy the upper digits and the sticky overflow at
// each edge with le high and hold otherwise. Assumes le is synchronous.
module bcd_disp_hold #(
    parameter int DISP_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              le,
    input  logic [DISP_W-1:0] digits_in,
    input  logic              ovf_in,
    output logic [DISP_W-1:0] digits_out,
    output logic              ovf_out
);

    // Capture the digits and the overflow while le is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            digits_out <= '0;
            ovf_out    <= 1'b0;
        end else if (le) begin
            digits_out <= digits_in;
            ovf_out    <= ovf_in;
        end
    end

    // R6
    disp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !le |=> $stable(digits_out));

    // R7
    disp_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        le |=> (ovf_out == $past(ovf_in)));

    // R7
    disp_ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !le |=> $stable(ovf_out));

endmodule

// File: rtl/bcd_count_chain.sv
// Top of the multi-entry BCD count chain: entry decoder, digit cascade with
// a same-cycle carry chain, sticky overflow, and display hold registers.
// Assumes NUM_DIGITS > 4 and DISP_DIGITS <= NUM_DIGITS.
module bcd_count_chain
    import bcd_chain_pkg::*;
#(
    parameter int NUM_DIGITS  = 8,
    parameter int DISP_DIGITS = 5
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cnt_pulse,
    input  logic [1:0]                   tap_sel,
    input  logic                         cnt_mode,
    input  logic                         ctr_clr,
    input  logic                         disp_le,
    output logic [DISP_DIGITS*BCD_W-1:0] disp_digits,
    output logic                         disp_ovf
);

    localparam int CHAIN_W    = NUM_DIGITS * BCD_W;
    localparam int DISP_W     = DISP_DIGITS * BCD_W;
    localparam int FIRST_DISP = NUM_DIGITS - DISP_DIGITS;

    logic [NUM_DIGITS-1:0] inject;
    logic [NUM_DIGITS-1:0] below;
    logic [NUM_DIGITS-1:0] step;
    logic [NUM_DIGITS-1:0] carry;
    logic [CHAIN_W-1:0]    chain;
    logic                  ovf_sticky;

    bcd_entry_sel #(
        .NUM_DIGITS (NUM_DIGITS)
    ) u_entry (
        .pulse    (cnt_pulse),
        .tap_sel  (tap_sel),
        .cnt_mode (cnt_mode),
        .inject   (inject),
        .below    (below)
    );

    for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_digit
        if (g == 0) begin : g_first
            // Lowest digit is fed only by injection.
            always_comb step[g] = inject[g];
        end else begin : g_upper
            // Upper digits take injection OR carry from below.
            always_comb step[g] = inject[g] | carry[g-1];
        end

        bcd_digit_cell u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr       (ctr_clr),
            .hold_zero (below[g]),
            .step      (step[g]),
            .val       (chain[g*BCD_W +: BCD_W]),
            .carry     (carry[g])
        );
    end

    // Sticky overflow set by a carry out of the top digit.
    always_ff @(posedge clk) begin
        if (!rst_n || ctr_clr) begin
            ovf_sticky <= 1'b0;
        end else if (carry[NUM_DIGITS-1]) begin
            ovf_sticky <= 1'b1;
        end
    end

    bcd_disp_hold #(
        .DISP_W (DISP_W)
    ) u_disp (
        .clk        (clk),
        .rst_n      (rst_n),
        .le         (disp_le),
        .digits_in  (chain[FIRST_DISP*BCD_W +: DISP_W]),
        .ovf_in     (ovf_sticky),
        .digits_out (disp_digits),
        .ovf_out    (disp_ovf)
    );

    // R2
    one_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(inject));

    // R2
    tap_u3_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_pulse && !cnt_mode && tap_sel == 2'd2) |-> inject[3]);

    // R3
    cnt_mode_tap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_pulse && cnt_mode) |-> inject[3]);

    // R4
    below_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        below[0] |=> (chain[BCD_W-1:0] == '0));

    // R5
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (carry[NUM_DIGITS-1] && !ctr_clr) |=> ovf_sticky);

    // R5
    ovf_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_sticky && !ctr_clr) |=> ovf_sticky);

    // R8
    clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctr_clr |=> (chain == '0 && !ovf_sticky));

    // R8
    clr_disp_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctr_clr && !disp_le) |=> ($stable(disp_digits) && $stable(disp_ovf)));

endmodule

// File: tb/bcd_count_chain_bench.sv
// Scoreboard bench: driver tasks keep a decimal model of the count, queue the
// expected display at each latch, and a monitor compares after the latch edge.
module bcd_count_chain_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_pulse = 1'b0;
    logic [1:0]  tap_sel = 2'd0;
    logic        cnt_mode = 1'b0;
    logic        ctr_clr = 1'b0;
    logic        disp_le = 1'b0;
    logic [19:0] disp_digits;
    logic        disp_ovf;

    int    n_checks = 0;
    int    n_errors = 0;
    bit    finished = 1'b0;
    longint model = 0;
    bit    model_ovf = 1'b0;
    logic [19:0] last_dig = '0;
    logic        last_ovf = 1'b0;

    logic [19:0] q_dig[$];
    logic        q_ovf[$];
    string       q_tag[$];

    always #2 clk = ~clk;

    bcd_count_chain u_bcd_count_chain (
        .clk         (clk),
        .rst_n       (rst_n),
        .cnt_pulse   (cnt_pulse),
        .tap_sel     (tap_sel),
        .cnt_mode    (cnt_mode),
        .ctr_clr     (ctr_clr),
        .disp_le     (disp_le),
        .disp_digits (disp_digits),
        .disp_ovf    (disp_ovf)
    );

    function automatic logic [19:0] to_disp(input longint v);
        logic [19:0] r;
        longint d;
        d = v / 1000;
        for (int i = 0; i < 5; i++) begin
            r[4*i +: 4] = 4'(d % 10);
            d = d / 10;
        end
        return r;
    endfunction

    function automatic longint pos_weight(input logic [1:0] sel, input logic mode);
        if (mode) return 1000;
        case (sel)
            2'd0:    return 1;
            2'd1:    return 10;
            2'd2:    return 1000;
            default: return 10000;
        endcase
    endfunction

    task automatic compare(input string tag, input logic [19:0] exp_d, input logic exp_o);
        n_checks++;
        if (disp_digits !== exp_d || disp_ovf !== exp_o) begin
            n_errors++;
            $display("FAIL %s: digits=%h ovf=%b expected digits=%h ovf=%b",
                     tag, disp_digits, disp_ovf, exp_d, exp_o);
        end
    endtask

    // Apply n back-to-back pulses at the given entry, updating the model.
    task automatic pulses(input int n, input logic [1:0] sel, input logic mode);
        longint w;
        w = pos_weight(sel, mode);
        @(negedge clk);
        tap_sel  = sel;
        cnt_mode = mode;
        model    = model - (model % w);
        for (int k = 0; k < n; k++) begin
            cnt_pulse = 1'b1;
            @(negedge clk);
            model = model + w;
            if (model >= 64'd100000000) begin
                model     = model - 64'd100000000;
                model_ovf = 1'b1;
            end
        end
        cnt_pulse = 1'b0;
        @(negedge clk);
        model = model - (model % w);
    endtask

    // Latch the display for one cycle and queue the predicted reading.
    task automatic latch(input string tag);
        @(negedge clk);
        disp_le = 1'b1;
        last_dig = to_disp(model);
        last_ovf = model_ovf;
        q_dig.push_back(last_dig);
        q_ovf.push_back(last_ovf);
        q_tag.push_back(tag);
        @(negedge clk);
        disp_le = 1'b0;
    endtask

    task automatic clear(input bit with_pulse);
        @(negedge clk);
        ctr_clr   = 1'b1;
        cnt_pulse = with_pulse;
        @(negedge clk);
        ctr_clr   = 1'b0;
        cnt_pulse = 1'b0;
        model     = 0;
        model_ovf = 1'b0;
    endtask

    // Monitor: after every latch edge, pop and compare the expected reading.
    initial begin
        forever begin
            @(posedge clk);
            if (disp_le && rst_n) begin
                @(negedge clk);
                if (q_dig.size() == 0) begin
                    n_checks++;
                    n_errors++;
                    $display("FAIL R6: latch with empty queue, digits=%h expected none", disp_digits);
                end else begin
                    compare(q_tag.pop_front(), q_dig.pop_front(), q_ovf.pop_front());
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: run hung, got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: outputs cleared by reset
        compare("R9 reset state", 20'h0, 1'b0);
        rst_n = 1'b1;

        // R2: entry at digit 3 (tap 2), small count
        pulses(7, 2'd2, 1'b0);
        latch("R2 tap 2 enters digit 3");

        // R1: carry across several displayed digits in one cycle
        pulses(993, 2'd2, 1'b0);
        latch("R1 carry ripple to digit 6");

        // R6: display holds while disp_le low
        pulses(5, 2'd2, 1'b0);
        compare("R6 hold without latch", last_dig, last_ovf);
        latch("R6 update on latch");

        // R8: clear wins over pulse, display untouched
        clear(1'b1);
        compare("R8 clear leaves display", last_dig, last_ovf);
        latch("R8 clear empties chain");

        // R2: digit 0 entry
        pulses(2500, 2'd0, 1'b0);
        latch("R2 tap 0 enters digit 0");
        clear(1'b0);

        // R2: digit 1 entry
        pulses(350, 2'd1, 1'b0);
        latch("R2 tap 1 enters digit 1");
        clear(1'b0);

        // R2: digit 4 entry
        pulses(12, 2'd3, 1'b0);
        latch("R2 tap 3 enters digit 4");
        clear(1'b0);

        // R3: counter mode overrides tap 0
        pulses(4, 2'd0, 1'b1);
        latch("R3 cnt_mode forces digit 3");
        clear(1'b0);

        // R4: remainder below entry dropped on switch
        pulses(999, 2'd0, 1'b0);
        pulses(1, 2'd2, 1'b0);
        pulses(1, 2'd0, 1'b0);
        latch("R4 lower digits cleared");
        clear(1'b0);

        // R5 and R7: overflow at digit 4 entry
        pulses(9999, 2'd3, 1'b0);
        latch("R5 just below overflow");
        pulses(2, 2'd3, 1'b0);
        compare("R7 overflow not shown before latch", last_dig, last_ovf);
        latch("R7 overflow shown at latch");
        pulses(3, 2'd3, 1'b0);
        latch("R5 overflow stays sticky");

        // R8: clear drops sticky, displayed flag holds until latch
        clear(1'b0);
        compare("R8 displayed ovf kept after clear", last_dig, last_ovf);
        latch("R7 cleared overflow latched");

        // R9: reset clears display
        pulses(20, 2'd2, 1'b0);
        latch("R9 before reset");
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        model = 0;
        model_ovf = 1'b0;
        compare("R9 reset clears display", 20'h0, 1'b0);
        latch("R9 chain cleared by reset");

        repeat (4) @(negedge clk);
        if (q_dig.size() != 0) begin
            n_checks++;
            n_errors++;
            $display("FAIL R6: %0d readings never compared, expected 0", q_dig.size());
        end
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule